// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This unit gathers event pulses from a clock and reset controller into a sticky status register and raises one level-sensitive interrupt line whenever any latched event is set and not masked. Software reads the status over a 32-bit register bus and clears the events it has handled by writing ones to them.

The mask register is read-only from the bus. Software changes it only through two command registers. Writing ones to the unmask command clears the matching mask bits. Writing ones to the mask command sets them. Neither command register holds the written value.

The bus accepts aligned 32-bit word accesses only. A read returns its data one cycle after the request. The interrupt output is registered, so it follows any register change one cycle later.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status register is zero, every mask bit is one, and `irq_o` is low.
- R2: A one on bit i of `evt_i` in a cycle sets status bit i at the next clock edge. The bit then stays set until software clears it.
- R3: A valid write to offset 0x0 (status) clears each status bit whose written data bit is one. Status bits written with zero are left unchanged.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A valid write to offset 0x8 (unmask command) clears each mask bit whose data bit is one. A valid write to offset 0xC (mask command) sets each mask bit whose data bit is one. Mask bits written with zero keep their value.
- R6: A write to offset 0x4 (mask) has no effect. A read of offset 0x4 returns the mask in bits [NUM_SRC-1:0].
- R7: Reads of offsets 0x8 and 0xC always return zero.
- R8: `irq_o` is high in the cycle after a clock edge exactly when the previous register state had any status bit set with its mask bit clear.
- R9: A write takes effect only when `bus_wstrb` is 4'hF, `bus_addr[1:0]` is zero, and the address is below 0x10. Any other write changes nothing. Reads of misaligned or out-of-range addresses return zero.
- R10: Every read request raises `bus_rvalid` for one cycle at the next clock edge, with `bus_rdata` valid in that cycle. Status read data has zeros above bit NUM_SRC-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_SRC | Event pulses, one per source |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wstrb | input | 4 | Byte strobes; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
Two functions can land on the same status bit in the same cycle: an event pulse setting the bit and a write-one-to-clear from software. The bench provokes this by driving `evt_i` during the very cycle in which the status write is presented. It then reads the status back and expects the bit to be set. A cycle-accurate reference model also compares `irq_o` and the read data on every clock, which catches any case where the collision leaves the interrupt line wrong.

// File: rtl/isu_pkg.sv
package isu_pkg;
    localparam int DATA_W = 32;

    localparam logic [3:0] OFF_STATUS  = 4'h0;
    localparam logic [3:0] OFF_MASK    = 4'h4;
    localparam logic [3:0] OFF_UNMASK  = 4'h8;
    localparam logic [3:0] OFF_SETMASK = 4'hC;

    typedef enum logic [2:0] {
        SEL_STATUS,
        SEL_MASK,
        SEL_UNMASK,
        SEL_SETMASK,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } access_t;
endpackage

// File: rtl/isu_decode.sv
module isu_decode
    import isu_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        wstrb,
    output access_t           acc
);
    logic     in_range;
    logic     aligned;
    reg_sel_e sel;

    always_comb begin
        in_range = (addr[ADDR_W-1:4] == '0);
        aligned  = (addr[1:0] == 2'b00);
        sel      = SEL_NONE;
        if (in_range && aligned) begin
            case (addr[3:2])
                2'd0:    sel = SEL_STATUS;
                2'd1:    sel = SEL_MASK;
                2'd2:    sel = SEL_UNMASK;
                default: sel = SEL_SETMASK;
            endcase
        end
        acc.rd  = req && !we;
        acc.wr  = req && we && (wstrb == 4'hF) && (sel != SEL_NONE);
        acc.sel = sel;
    end
endmodule

// File: rtl/isu_regfile.sv
module isu_regfile
    import isu_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  access_t           acc_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              rvalid_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] status;
        logic [NUM_SRC-1:0] mask;
        logic               irq;
        logic               rvalid;
        logic [DATA_W-1:0]  rdata;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_SRC-1:0] clr_d;
    logic [NUM_SRC-1:0] wbits;
    logic               unused_wdata_hi;

    assign wbits           = wdata_i[NUM_SRC-1:0];
    assign unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_SRC];

    always_comb begin
        st_d  = st_q;
        clr_d = '0;
        if (acc_i.wr) begin
            case (acc_i.sel)
                SEL_STATUS:  clr_d = wbits;
                SEL_UNMASK:  st_d.mask = st_q.mask & ~wbits;
                SEL_SETMASK: st_d.mask = st_q.mask | wbits;
                default:     ;
            endcase
        end
        st_d.status = (st_q.status & ~clr_d) | evt_i;
        st_d.irq    = |(st_q.status & ~st_q.mask);
        st_d.rvalid = acc_i.rd;
        st_d.rdata  = '0;
        if (acc_i.rd) begin
            case (acc_i.sel)
                SEL_STATUS: st_d.rdata = DATA_W'(st_q.status);
                SEL_MASK:   st_d.rdata = DATA_W'(st_q.mask);
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.status <= '0;
            st_q.mask   <= '1;
            st_q.irq    <= 1'b0;
            st_q.rvalid <= 1'b0;
            st_q.rdata  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rvalid_o = st_q.rvalid;
    assign rdata_o  = st_q.rdata;
    assign irq_o    = st_q.irq;

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_i.wr && acc_i.sel == SEL_STATUS) |=> ((st_q.status & $past(st_q.status)) == $past(st_q.status)))
        else $error("status bit fell without a clear"); // R2
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((st_q.status & $past(evt_i)) == $past(evt_i)))
        else $error("event pulse lost"); // R4
    AST_MASK_NO_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_i.wr && (acc_i.sel == SEL_UNMASK || acc_i.sel == SEL_SETMASK)) |=> $stable(st_q.mask))
        else $error("mask changed without a command"); // R6
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&st_q.mask) |=> !st_q.irq)
        else $error("irq raised while fully masked"); // R8
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import isu_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [3:0]         bus_wstrb,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic               bus_rvalid,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);
    access_t acc;

    isu_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req   (bus_req),
        .we    (bus_we),
        .addr  (bus_addr),
        .wstrb (bus_wstrb),
        .acc   (acc)
    );

    isu_regfile #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .acc_i    (acc),
        .wdata_i  (bus_wdata),
        .rvalid_o (bus_rvalid),
        .rdata_o  (bus_rdata),
        .irq_o    (irq_o)
    );

    AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && (bus_addr == ADDR_W'(OFF_UNMASK) || bus_addr == ADDR_W'(OFF_SETMASK)))
        |=> (bus_rvalid && bus_rdata == '0))
        else $error("command register read nonzero"); // R7
    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr[1:0] != 2'b00) |=> (bus_rdata == '0))
        else $error("misaligned read returned data"); // R9
endmodule

// File: tb/tb_irq_status_unit.sv
`timescale 1ns/1ps
module tb_irq_status_unit;
    localparam int NSRC = 4;
    localparam int AW   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] evt = '0;
    logic            req = 1'b0;
    logic            we = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [3:0]      strb = 4'h0;
    logic [31:0]     wdata = '0;
    logic            rvalid;
    logic [31:0]     rdata;
    logic            irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    irq_status_unit #(.NUM_SRC(NSRC), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .bus_req(req), .bus_we(we), .bus_addr(addr), .bus_wstrb(strb),
        .bus_wdata(wdata), .bus_rvalid(rvalid), .bus_rdata(rdata), .irq_o(irq)
    );

    always #10 clk = ~clk;

    // Behavioural reference model
    logic [NSRC-1:0] m_status, m_mask;
    logic            m_irq, m_rvalid;
    logic [31:0]     m_rdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_status <= '0; m_mask <= '1; m_irq <= 1'b0;
            m_rvalid <= 1'b0; m_rdata <= '0;
        end else begin
            logic ok;
            logic [NSRC-1:0] st, mk;
            ok = (addr < 16) && (addr % 4 == 0);
            st = m_status; mk = m_mask;
            if (req && we && ok && strb == 4'hF) begin
                if (addr == 0)  st = st & ~wdata[NSRC-1:0];
                if (addr == 8)  mk = mk & ~wdata[NSRC-1:0];
                if (addr == 12) mk = mk | wdata[NSRC-1:0];
            end
            m_irq    <= (m_status & ~m_mask) != 0;
            m_rvalid <= req && !we;
            m_rdata  <= (req && !we && ok && addr == 0) ? 32'(m_status) :
                        (req && !we && ok && addr == 4) ? 32'(m_mask) : 32'h0;
            m_status <= st | evt;
            m_mask   <= mk;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(irq === m_irq, "R8 irq vs model", 32'(irq), 32'(m_irq));
            check(rvalid === m_rvalid, "R10 rvalid vs model", 32'(rvalid), 32'(m_rvalid));
            if (m_rvalid) check(rdata === m_rdata, "R10 rdata vs model", rdata, m_rdata);
        end
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s);
        req = 1'b1; we = 1'b1; addr = a; wdata = d; strb = s;
        @(negedge clk);
        req = 1'b0; we = 1'b0; strb = 4'h0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        check(rvalid === 1'b1, "R10 rvalid after read", 32'(rvalid), 32'h1);
        check(rdata === exp, tag, rdata, exp);
    endtask

    task automatic pulse(input logic [NSRC-1:0] e);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(irq === 1'b0, "R1 irq low after reset", 32'(irq), 32'h0);
        bus_read(8'h00, 32'h0, "R1 status zero after reset");
        bus_read(8'h04, 32'hF, "R1 mask all ones after reset");

        pulse(4'b0101);
        bus_read(8'h00, 32'h5, "R2 events latched");
        check(irq === 1'b0, "R8 masked events keep irq low", 32'(irq), 32'h0);

        bus_write(8'h08, 32'h1, 4'hF);
        bus_read(8'h04, 32'hE, "R5 unmask clears bit 0");
        check(irq === 1'b1, "R8 irq after unmask", 32'(irq), 32'h1);
        bus_read(8'h08, 32'h0, "R7 unmask reads zero");
        bus_read(8'h0C, 32'h0, "R7 setmask reads zero");

        bus_write(8'h04, 32'h0, 4'hF);
        bus_read(8'h04, 32'hE, "R6 direct mask write ignored");

        bus_write(8'h00, 32'h5, 4'h3);
        bus_read(8'h00, 32'h5, "R9 partial strobe ignored");
        bus_write(8'h01, 32'h5, 4'hF);
        bus_read(8'h00, 32'h5, "R9 misaligned write ignored");
        bus_write(8'h40, 32'hF, 4'hF);
        bus_read(8'h00, 32'h5, "R9 out of range write ignored");
        bus_read(8'h02, 32'h0, "R9 misaligned read zero");

        bus_write(8'h00, 32'h4, 4'hF);
        bus_read(8'h00, 32'h1, "R3 w1c clears bit 2 only");
        bus_write(8'h00, 32'h1, 4'hF);
        @(negedge clk);
        check(irq === 1'b0, "R8 irq drops after clear", 32'(irq), 32'h0);
        bus_read(8'h00, 32'h0, "R3 status cleared");

        pulse(4'b0010);
        evt = 4'b0010;
        bus_write(8'h00, 32'h2, 4'hF);
        evt = '0;
        bus_read(8'h00, 32'h2, "R4 set wins over clear");

        bus_write(8'h08, 32'h2, 4'hF);
        bus_read(8'h04, 32'hC, "R5 unmask bit 1");
        check(irq === 1'b1, "R8 irq from bit 1", 32'(irq), 32'h1);
        bus_write(8'h0C, 32'h3, 4'hF);
        bus_read(8'h04, 32'hF, "R5 setmask restores bits");
        check(irq === 1'b0, "R8 irq off after remask", 32'(irq), 32'h0);

        pulse(4'hF);
        bus_read(8'h00, 32'hF, "R10 status upper bits zero");
        bus_read(8'h00, 32'hF, "R2 events remain sticky");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule